// File: doc/BRIEF.md
# DDR Read Data and Strobe Sequencer

This block stands on the memory side of a DDR SDRAM model and produces the read return path. It accepts already-decoded READ and BURST STOP commands. A READ carries a bank, a row and a starting column. A fixed number of clocks after the READ (the CAS latency), the block drives data element pairs. Each clock cycle carries two lanes: one for the element that belongs to the rising clock half and one for the element that belongs to the falling half. Alongside the data it drives a strobe with an output enable. The strobe has a low preamble before the data and a low postamble after it, and it returns to high impedance when nothing follows.

Bursts can be chained without a gap, cut short by a later READ, or ended early by BURST STOP. A stop takes effect after the same latency as a read. No array is stored: each element's value is a fixed arithmetic pattern of bank, row and column, so the value is known ahead of time.

Top module: `ddr_rd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `dq_oe` and `dqs_oe` are 0.
- R2: A READ sampled at the clock edge that ends cycle t puts its first element pair on the lanes in cycle t+CAS_LAT, with `dq_oe`=1. The starting column is on `dq_rise`, and the next column of the burst is on `dq_fall`.
- R3: An uninterrupted burst delivers BURST_LEN elements over BURST_LEN/2 consecutive cycles. Element e of a burst that starts at column s uses column (s - s mod BURST_LEN) + ((s mod BURST_LEN + e) mod BURST_LEN), so the columns wrap inside their BURST_LEN-aligned block.
- R4: The value of an element at bank b, row r and column c is the low DQ_W bits of (37*r) XOR (2*c) XOR (256*b) XOR 0xA5A5.
- R5: In a cycle with no data that comes directly before a data cycle (the preamble), `dqs_oe`=1 and `dqs_level`=0.
- R6: In every data cycle, `dqs_oe`=1 and `dqs_level`=1. Here `dqs_level` is the strobe level in the rising half; the falling half is the opposite level.
- R7: In a cycle with no data that comes directly after a data cycle (the postamble), `dqs_oe`=1 and `dqs_level`=0. When a cycle is none of data, preamble or postamble, `dqs_oe`=0.
- R8: A READ issued exactly BURST_LEN/2 cycles after the previous READ makes its first pair follow the previous burst's last pair with no idle cycle.
- R9: A READ issued before the previous burst has finished truncates that burst. The old burst's pairs stop at cycle t+CAS_LAT, where t is the cycle of the new READ, and the new burst starts there.
- R10: A BURST STOP in cycle s removes every pair that would appear from cycle s+CAS_LAT onward, so `dq_oe` is 0 in that cycle. A BURST STOP with no burst in progress changes no output.
- R11: When READ and BURST STOP are sampled in the same cycle, the READ is carried out and the stop is ignored.
- R12: When `dq_oe` is 0, both `dq_rise` and `dq_fall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Decoded READ command |
| stop_req | input | 1 | Decoded BURST STOP command |
| cmd_bank | input | BANK_W | Bank of the READ |
| cmd_row | input | ROW_W | Open row of the addressed bank |
| cmd_col | input | COL_W | Starting column of the READ |
| dq_rise | output | DQ_W | Element for the rising clock half |
| dq_fall | output | DQ_W | Element for the falling clock half |
| dq_oe | output | 1 | Data lanes driven |
| dqs_level | output | 1 | Strobe level in the rising half |
| dqs_oe | output | 1 | Strobe driven; 0 means high impedance |

## Verification
The bench builds the block with CAS_LAT=3 and BURST_LEN=4, so each burst takes two pair cycles. With these values, a READ one cycle after another truncates the first burst, and a READ two cycles later chains with no gap. A gap of one idle cycle makes a postamble and a preamble fall on the same cycle. A latency of three also leaves a stop in flight in the pipe while further commands arrive, so stop and truncation can overlap. Starting columns are random, including odd values and values at the end of a block, so the column wrap is exercised in both lanes.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  // Column of element 'elem' in a burst starting at 'base', wrapping inside
  // a block of 'bl' columns (bl is a power of two).
  function automatic int unsigned burst_col(input int unsigned base,
                                            input int unsigned elem,
                                            input int unsigned bl);
    return (base & ~(bl - 1)) | ((base + elem) & (bl - 1));
  endfunction

  // Deterministic element value standing in for array contents.
  function automatic int unsigned elem_pattern(input int unsigned bank,
                                               input int unsigned row,
                                               input int unsigned col);
    return (row * 37) ^ (col << 1) ^ (bank << 8) ^ 32'h0000_A5A5;
  endfunction

endpackage

// File: rtl/ddr_rd_engine.sv
module ddr_rd_engine
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              stop_req,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic              slot_valid,
  output logic [BANK_W-1:0] slot_bank,
  output logic [ROW_W-1:0]  slot_row,
  output logic [COL_W-1:0]  slot_col
);
  localparam int PAIRS = BURST_LEN / 2;
  localparam int IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic              act_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  base_q;
  logic [IDX_W-1:0]  idx_q;

  // Named internal events
  logic rd_take, stop_take, burst_last;
  assign rd_take    = rd_req;               // READ wins over STOP
  assign stop_take  = stop_req & ~rd_req;
  assign burst_last = act_q && (idx_q == IDX_W'(PAIRS - 1));

  // Pair emitted this cycle (enters the latency pipe)
  always_comb begin
    slot_valid = 1'b0;
    slot_bank  = bank_q;
    slot_row   = row_q;
    slot_col   = base_q;
    if (rd_take) begin
      slot_valid = 1'b1;
      slot_bank  = bank;
      slot_row   = row;
      slot_col   = col;
    end else if (!stop_take && act_q) begin
      slot_valid = 1'b1;
      slot_col   = COL_W'(burst_col(32'(base_q), 32'(idx_q) * 2, BURST_LEN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (rd_take) begin
      act_q  <= (PAIRS > 1);
      bank_q <= bank;
      row_q  <= row;
      base_q <= col;
      idx_q  <= IDX_W'(1);
    end else if (stop_take) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (burst_last) act_q <= 1'b0;
      else            idx_q <= idx_q + IDX_W'(1);
    end
  end

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (32'(idx_q) < PAIRS) && (idx_q != '0));

  assert_stop_silence_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_take) && !rd_take) |-> !slot_valid);

  assert_read_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && stop_req) |=> act_q == (PAIRS > 1));

  assert_burst_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_last && !rd_req) |=> !act_q);

endmodule

// File: rtl/ddr_rd_delay.sv
module ddr_rd_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] out_now,
  output logic         ahead_msb
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= in_vec;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign out_now   = stg[DEPTH-1];
  assign ahead_msb = stg[DEPTH-2][W-1];

endmodule

// File: rtl/ddr_rd_drive.sv
module ddr_rd_drive
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_valid,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic [COL_W-1:0]  cur_col,
  input  logic              next_valid,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic              dq_oe,
  output logic              dqs_level,
  output logic              dqs_oe
);
  logic prev_q;
  logic preamble_win, postamble_win;
  logic [COL_W-1:0] fall_col;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur_valid;
  end

  assign preamble_win  = next_valid & ~cur_valid;
  assign postamble_win = prev_q & ~cur_valid;
  assign fall_col      = COL_W'(burst_col(32'(cur_col), 1, BURST_LEN));

  always_comb begin
    dq_rise = '0;
    dq_fall = '0;
    if (cur_valid) begin
      dq_rise = DQ_W'(elem_pattern(32'(cur_bank), 32'(cur_row), 32'(cur_col)));
      dq_fall = DQ_W'(elem_pattern(32'(cur_bank), 32'(cur_row), 32'(fall_col)));
    end
  end

  assign dq_oe     = cur_valid;
  assign dqs_level = cur_valid;
  assign dqs_oe    = cur_valid | preamble_win | postamble_win;

  assert_preamble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe) && !$past(dqs_level));

  assert_strobe_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe && dqs_level);

  assert_postamble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> dqs_oe && !dqs_level);

  assert_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dq_oe) && !dq_oe && !next_valid) |-> !dqs_oe);

  assert_idle_lanes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_rise == '0) && (dq_fall == '0));

endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 16,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              stop_req,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic              dq_oe,
  output logic              dqs_level,
  output logic              dqs_oe
);
  localparam int SLOT_W = 1 + BANK_W + ROW_W + COL_W;

  logic              s_valid;
  logic [BANK_W-1:0] s_bank;
  logic [ROW_W-1:0]  s_row;
  logic [COL_W-1:0]  s_col;
  logic [SLOT_W-1:0] pipe_in, pipe_out;
  logic              pipe_ahead;

  ddr_rd_engine #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .stop_req(stop_req),
    .bank(cmd_bank), .row(cmd_row), .col(cmd_col),
    .slot_valid(s_valid), .slot_bank(s_bank), .slot_row(s_row), .slot_col(s_col)
  );

  assign pipe_in = {s_valid, s_bank, s_row, s_col};

  ddr_rd_delay #(.W(SLOT_W), .DEPTH(CAS_LAT)) u_delay (
    .clk(clk), .rst_n(rst_n), .in_vec(pipe_in),
    .out_now(pipe_out), .ahead_msb(pipe_ahead)
  );

  ddr_rd_drive #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .BURST_LEN(BURST_LEN)
  ) u_drive (
    .clk(clk), .rst_n(rst_n),
    .cur_valid(pipe_out[SLOT_W-1]),
    .cur_bank(pipe_out[SLOT_W-2 -: BANK_W]),
    .cur_row(pipe_out[COL_W +: ROW_W]),
    .cur_col(pipe_out[COL_W-1:0]),
    .next_valid(pipe_ahead),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .dqs_level(dqs_level), .dqs_oe(dqs_oe)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> !dq_oe && !dqs_oe);

endmodule

// File: tb/ddr_rd_seq_bench.sv
module ddr_rd_seq_bench;
  localparam int BANK_W = 2, ROW_W = 12, COL_W = 9, DQ_W = 16;
  localparam int CL = 3, BL = 4, PAIRS = BL / 2;
  localparam int NCYC = 4096;

  logic clk = 1'b0, rst_n = 1'b0, rd_req = 1'b0, stop_req = 1'b0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [ROW_W-1:0]  cmd_row = '0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic [DQ_W-1:0]   dq_rise, dq_fall;
  logic dq_oe, dqs_level, dqs_oe;

  ddr_rd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
               .CAS_LAT(CL), .BURST_LEN(BL)) u_ddr_rd_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .stop_req(stop_req),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .dqs_level(dqs_level), .dqs_oe(dqs_oe));

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  string cur_tag = "R2_R3_R4";
  bit ev [NCYC];
  int eb [NCYC], er [NCYC], ec [NCYC];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wrap_col(int s, int e);
    int lo = s % BL;
    return (s - lo) + ((lo + e) % BL);
  endfunction

  function automatic logic [DQ_W-1:0] exp_val(int b, int r, int c);
    int v = ((r << 5) + (r << 2) + r) ^ (c * 2) ^ (b * 256) ^ 16'hA5A5;
    return v[DQ_W-1:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_cycle();
    int n = cyc;
    bit vp = (n > 0) ? ev[n-1] : 1'b0;
    chk({cur_tag, " dq_oe"}, 32'(dq_oe), 32'(ev[n]));
    if (ev[n]) begin
      chk({cur_tag, " dq_rise"}, 32'(dq_rise), 32'(exp_val(eb[n], er[n], ec[n])));
      chk({cur_tag, " dq_fall"}, 32'(dq_fall),
          32'(exp_val(eb[n], er[n], wrap_col(ec[n], 1))));
    end else begin
      chk("R12 idle lanes", {dq_rise, dq_fall}, 32'd0);
    end
    chk("R5_R6_R7 dqs_oe", 32'(dqs_oe), 32'(ev[n] | ev[n+1] | vp));
    if (dqs_oe) chk("R5_R6_R7 dqs_level", 32'(dqs_level), 32'(ev[n]));
  endtask

  // One command cycle: check outputs, then drive and record the expectation.
  task automatic step(bit rd, bit st, int b, int r, int c);
    @(negedge clk);
    check_cycle();
    rd_req = rd; stop_req = st;
    cmd_bank = BANK_W'(b); cmd_row = ROW_W'(r); cmd_col = COL_W'(c);
    if (rd) begin
      for (int k = 0; k < PAIRS; k++) begin
        ev[cyc+CL+k] = 1'b1; eb[cyc+CL+k] = b; er[cyc+CL+k] = r;
        ec[cyc+CL+k] = wrap_col(c, 2 * k);
      end
      for (int k = PAIRS; k < 2 * PAIRS; k++) ev[cyc+CL+k] = 1'b0;
    end else if (st) begin
      for (int k = 0; k < PAIRS; k++) ev[cyc+CL+k] = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCYC; i++) ev[i] = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset dq_oe", 32'(dq_oe), 32'd0);
      chk("R1 reset dqs_oe", 32'(dqs_oe), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset dqs_oe", 32'(dqs_oe), 32'd0);
    idle(2);

    cur_tag = "R2_R3_R4 single";      step(1, 0, 1, 100, 8);  idle(8);
    cur_tag = "R3 wrap odd start";    step(1, 0, 2, 7, 7);    idle(8);
    cur_tag = "R8 seamless";          step(1, 0, 0, 5, 4);  idle(PAIRS - 1);
                                      step(1, 0, 3, 6, 13);   idle(8);
    cur_tag = "R5_R7 one-cycle gap";  step(1, 0, 0, 9, 0);  idle(PAIRS);
                                      step(1, 0, 1, 9, 2);    idle(8);
    cur_tag = "R9 truncate";          step(1, 0, 2, 11, 4);
                                      step(1, 0, 3, 12, 9);   idle(8);
    cur_tag = "R10 stop mid-burst";   step(1, 0, 1, 20, 0);
                                      step(0, 1, 0, 0, 0);    idle(8);
    cur_tag = "R10 stop while idle";  step(0, 1, 0, 0, 0);    idle(8);
    cur_tag = "R11 read beats stop";  step(1, 1, 2, 30, 5);   idle(8);

    cur_tag = "R2_R3_R4_R8_R9_R10 random";
    for (int i = 0; i < 2500; i++) begin
      int p = $urandom_range(99);
      step(p < 30, (p >= 30 && p < 40) || p == 0,
           $urandom_range(3), $urandom_range(4095), $urandom_range(511));
    end
    idle(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule